// File: doc/BRIEF.md
# Dual-Clock Ping-Pong Frame Buffer

This block turns an interlaced, slowly clocked monochrome picture into a progressive picture read at a faster, unrelated display clock. It holds two one-bit-per-pixel banks. The capture side fills one bank while the display side reads the other. The banks change roles only after a full frame, meaning two fields, has been stored. Pixels of the even field go to even locations and pixels of the odd field go to odd locations of the same bank. A stored line is therefore the two fields woven together, which deinterlaces the picture.

The capture side provides a pixel bit, a window-valid flag and strobes that mark the start of a line and the start of a field. It derives write addresses from an internal walker and needs no multiplier. The display side provides pixel coordinates inside its visible window, a visible flag and a strobe at the start of vertical blanking. Each stored location is shown as a 2x2 block of display pixels. The display bank changes only at that blanking strobe, so a shown picture is never torn. A completed-frame indication crosses into the display domain through a two-flop synchronizer.

With `CAP_W` active pixels per field line and `CAP_LINES` lines per field, a stored line spans `2*CAP_W` locations. The display window is `4*CAP_W` by `2*CAP_LINES` pixels.

Top module: `fb_pingpong`

## Requirements
- R1: After reset the output is 0. It stays 0, even inside the visible window and across blanking strobes, until a complete frame has been captured and a vertical blanking strobe has followed it.
- R2: A pixel is stored only in a cycle where `cap_active` is 1. Pixel values presented with `cap_active` at 0 never appear on the display.
- R3: The first field after reset is even (parity 0), and every field start toggles the parity. Active pixel k of field line n is stored at location n*2*CAP_W + 2*k + parity.
- R4: The capture bank starts at bank 0. It flips at a field start that ends an odd field, so it changes once per two fields. Each completed frame lands in the bank opposite the previous one.
- R5: Active pixels past the CAP_W-th on a line are discarded and do not spill into the next line. Lines past the CAP_LINES-th of a field are discarded.
- R6: If a line start and an active pixel fall in the same capture cycle, the line start takes effect first, and that pixel is stored as column 0 of the new line.
- R7: The displayed bank changes only in the cycle after a vertical blanking strobe. It then switches to the bank holding the newest completed frame. Without a strobe, the previous picture stays on the display.
- R8: Display pixel (x, y) shows stored location (y/2)*2*CAP_W + x/2, using integer division.
- R9: `disp_pix` follows the presented coordinates by exactly one display clock. When `disp_vis` was 0 in the previous cycle, it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_clk | input | 1 | Capture pixel clock |
| cap_rst | input | 1 | Synchronous active-high reset, capture domain |
| cap_pix | input | 1 | Captured pixel bit |
| cap_active | input | 1 | Capture position is inside the active picture |
| cap_line_start | input | 1 | One-cycle strobe: a new field line begins |
| cap_field_start | input | 1 | One-cycle strobe: a new field begins (capture vertical sync) |
| disp_clk | input | 1 | Display pixel clock |
| disp_rst | input | 1 | Synchronous active-high reset, display domain |
| disp_x | input | XW | Column inside the visible window |
| disp_y | input | YW | Row inside the visible window |
| disp_vis | input | 1 | Display position is inside the visible window |
| disp_vblank_start | input | 1 | One-cycle strobe at the start of display vertical blanking |
| disp_pix | output | 1 | Display pixel bit, one display clock after the coordinates |

## Verification
Two collisions in the same cycle are exercised. On the capture side, one frame is written with every line start in the same cycle as the first active pixel of that line. That frame also carries extra active pixels at the end of each line and set pixel bits while the window is inactive. Any misordering of the line start against the write, and any spill past the line end, then shows up as a wrong bit in the full-window sweep compared against the arithmetic pattern. On the display side, a completed frame and a pending blanking strobe are kept apart on purpose. The window is swept once before the strobe, where the old picture is expected, and once after it, where the new one is expected, so the bank hand-over is judged on both sides of the strobe.

// File: rtl/fb_pkg.sv
package fb_pkg;

    // Tag that travels with a display read through the one-cycle RAM latency
    typedef struct packed {
        logic vis;   // coordinate was inside the visible window
        logic bank;  // bank the read was issued to
        logic live;  // a completed frame has been shown at least once
    } rd_tag_t;

    // Locations per bank: two fields of lines x pixels
    function automatic int unsigned frame_locs(int unsigned w, int unsigned l);
        return 2 * w * l;
    endfunction

    // Bits needed to index 0..n-1, never less than one
    function automatic int unsigned bits_for(int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/fb_dpram.sv
module fb_dpram #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned AW    = 10
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wdata,
    input  logic          rclk,
    input  logic [AW-1:0] raddr,
    output logic          rdata
);

    logic mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we && (32'(waddr) < DEPTH)) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/fb_capture.sv
module fb_capture #(
    parameter int unsigned CAP_W     = 32,
    parameter int unsigned CAP_LINES = 16,
    parameter int unsigned AW        = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix,
    input  logic          active,
    input  logic          line_start,
    input  logic          field_start,
    output logic          we,
    output logic          bank,
    output logic [AW-1:0] waddr,
    output logic          wdata,
    output logic          wr_sel
);

    localparam int unsigned LINE_LOCS = 2 * CAP_W;
    localparam int unsigned DEPTH     = LINE_LOCS * CAP_LINES;
    localparam int unsigned BW        = AW + 1;
    localparam logic [BW-1:0] LINE_B  = BW'(LINE_LOCS);
    localparam logic [BW-1:0] DEPTH_B = BW'(DEPTH);
    localparam logic [BW-1:0] STEP_B  = BW'(2);

    logic          parity, armed, line_had;
    logic [BW-1:0] line_base, col_off;

    logic          nxt_par, nxt_had, nxt_sel, wr_ok;
    logic [BW-1:0] nxt_base, nxt_off;

    always_comb begin
        nxt_par  = parity;
        nxt_base = line_base;
        nxt_off  = col_off;
        nxt_had  = line_had;
        nxt_sel  = wr_sel;
        if (field_start) begin
            nxt_par  = ~parity;
            nxt_base = '0;
            nxt_off  = {{(BW-1){1'b0}}, ~parity};
            nxt_had  = 1'b0;
            if (armed && parity) begin
                nxt_sel = ~wr_sel;
            end
        end else if (line_start) begin
            if (line_had) begin
                nxt_base = line_base + LINE_B;
            end
            nxt_off = {{(BW-1){1'b0}}, parity};
            nxt_had = 1'b0;
        end
        wr_ok = (armed || field_start) && active
                && (nxt_off < LINE_B) && (nxt_base < DEPTH_B);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            parity    <= 1'b1;
            armed     <= 1'b0;
            wr_sel    <= 1'b0;
            line_base <= '0;
            col_off   <= '0;
            line_had  <= 1'b0;
        end else begin
            parity    <= nxt_par;
            armed     <= armed | field_start;
            wr_sel    <= nxt_sel;
            line_base <= nxt_base;
            col_off   <= wr_ok ? (nxt_off + STEP_B) : nxt_off;
            line_had  <= nxt_had | wr_ok;
        end
    end

    assign we    = wr_ok;
    assign bank  = nxt_sel;
    assign waddr = AW'(nxt_base + nxt_off);
    assign wdata = pix;

    // R4: the capture bank only moves right after a field start that closed an odd field
    assert_bank_flip_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(wr_sel) |-> ($past(field_start) && $past(parity)));

    // R3: each field start toggles the parity
    assert_parity_toggle_R3: assert property (@(posedge clk) disable iff (rst)
        field_start |=> (parity != $past(parity)));

    // R3: parity is held between field starts
    assert_parity_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !field_start |=> $stable(parity));

endmodule

// File: rtl/fb_display.sv
module fb_display
    import fb_pkg::*;
#(
    parameter int unsigned CAP_W = 32,
    parameter int unsigned AW    = 10,
    parameter int unsigned XW    = 7,
    parameter int unsigned YW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_sel_async,
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic          vis,
    input  logic          vblank_start,
    input  logic [1:0]    bank_q,
    output logic [AW-1:0] raddr,
    output logic          pix
);

    localparam int unsigned LINE_LOCS = 2 * CAP_W;

    logic    sync1, sync2;
    logic    rd_sel, live;
    rd_tag_t tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1  <= 1'b0;
            sync2  <= 1'b0;
            rd_sel <= 1'b1;
            live   <= 1'b0;
            tag    <= '0;
        end else begin
            sync1 <= wr_sel_async;
            sync2 <= sync1;
            if (vblank_start && (sync2 == rd_sel)) begin
                rd_sel <= ~sync2;
                live   <= 1'b1;
            end
            tag <= '{vis: vis, bank: rd_sel, live: live};
        end
    end

    assign raddr = AW'(32'(y >> 1) * LINE_LOCS + 32'(x >> 1));
    assign pix   = tag.vis & tag.live & bank_q[tag.bank];

    // R7: the shown bank moves only after a vertical blanking strobe
    assert_swap_at_blank_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_sel) |-> $past(vblank_start));

    // R1: nothing is shown before the first hand-over
    assert_black_first_R1: assert property (@(posedge clk) disable iff (rst)
        !live |=> !pix);

    // R9: outside the visible window the next output is dark
    assert_dark_outside_R9: assert property (@(posedge clk) disable iff (rst)
        !vis |=> !pix);

endmodule

// File: rtl/fb_pingpong.sv
module fb_pingpong
    import fb_pkg::*;
#(
    parameter int unsigned CAP_W     = 32,
    parameter int unsigned CAP_LINES = 16,
    parameter int unsigned XW        = bits_for(4 * CAP_W),
    parameter int unsigned YW        = bits_for(2 * CAP_LINES)
) (
    input  logic          cap_clk,
    input  logic          cap_rst,
    input  logic          cap_pix,
    input  logic          cap_active,
    input  logic          cap_line_start,
    input  logic          cap_field_start,
    input  logic          disp_clk,
    input  logic          disp_rst,
    input  logic [XW-1:0] disp_x,
    input  logic [YW-1:0] disp_y,
    input  logic          disp_vis,
    input  logic          disp_vblank_start,
    output logic          disp_pix
);

    localparam int unsigned DEPTH = frame_locs(CAP_W, CAP_LINES);
    localparam int unsigned AW    = bits_for(DEPTH);

    logic          cap_we, cap_bank, cap_wdata, cap_sel;
    logic [AW-1:0] cap_waddr, rd_addr;
    logic [1:0]    bank_q;

    fb_capture #(
        .CAP_W    (CAP_W),
        .CAP_LINES(CAP_LINES),
        .AW       (AW)
    ) u_capture (
        .clk        (cap_clk),
        .rst        (cap_rst),
        .pix        (cap_pix),
        .active     (cap_active),
        .line_start (cap_line_start),
        .field_start(cap_field_start),
        .we         (cap_we),
        .bank       (cap_bank),
        .waddr      (cap_waddr),
        .wdata      (cap_wdata),
        .wr_sel     (cap_sel)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        fb_dpram #(
            .DEPTH(DEPTH),
            .AW   (AW)
        ) u_ram (
            .wclk (cap_clk),
            .we   (cap_we && (cap_bank == 1'(b))),
            .waddr(cap_waddr),
            .wdata(cap_wdata),
            .rclk (disp_clk),
            .raddr(rd_addr),
            .rdata(bank_q[b])
        );
    end

    fb_display #(
        .CAP_W(CAP_W),
        .AW   (AW),
        .XW   (XW),
        .YW   (YW)
    ) u_display (
        .clk         (disp_clk),
        .rst         (disp_rst),
        .wr_sel_async(cap_sel),
        .x           (disp_x),
        .y           (disp_y),
        .vis         (disp_vis),
        .vblank_start(disp_vblank_start),
        .bank_q      (bank_q),
        .raddr       (rd_addr),
        .pix         (disp_pix)
    );

endmodule

// File: tb/test_fb_pingpong.sv
module test_fb_pingpong;

    localparam int CW = 4;
    localparam int CL = 3;
    localparam int DW = 4 * CW;
    localparam int DH = 2 * CL;
    localparam int XW = fb_pkg::bits_for(DW);
    localparam int YW = fb_pkg::bits_for(DH);

    logic          cap_clk = 1'b0, disp_clk = 1'b0;
    logic          cap_rst, cap_pix, cap_active, cap_line_start, cap_field_start;
    logic          disp_rst, disp_vis, disp_vblank_start;
    logic [XW-1:0] disp_x;
    logic [YW-1:0] disp_y;
    logic          disp_pix;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 disp_clk = ~disp_clk;  // 200 MHz display clock
    always #6.5 cap_clk  = ~cap_clk;   // slower, unrelated capture clock

    fb_pingpong #(.CAP_W(CW), .CAP_LINES(CL)) i_fb_pingpong (
        .cap_clk          (cap_clk),
        .cap_rst          (cap_rst),
        .cap_pix          (cap_pix),
        .cap_active       (cap_active),
        .cap_line_start   (cap_line_start),
        .cap_field_start  (cap_field_start),
        .disp_clk         (disp_clk),
        .disp_rst         (disp_rst),
        .disp_x           (disp_x),
        .disp_y           (disp_y),
        .disp_vis         (disp_vis),
        .disp_vblank_start(disp_vblank_start),
        .disp_pix         (disp_pix)
    );

    function automatic logic pat(int f, int fld, int ln, int col);
        int h;
        h = f * 13 + fld * 7 + ln * 5 + col * 3 + ln * col + f * col;
        return logic'((h >> 1) & 1);
    endfunction

    task automatic check(logic act, logic exp, string req, int x, int y);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at (%0d,%0d): got %b expected %b", req, x, y, act, exp);
        end
    endtask

    task automatic fs_pulse();
        @(negedge cap_clk) cap_field_start = 1'b1;
        @(negedge cap_clk) cap_field_start = 1'b0;
    endtask

    // one field: merged puts the line start on the first active pixel,
    // junk adds inactive set bits and overrun pixels set to 1
    task automatic cap_field(int f, int fld, bit merged, bit junk);
        for (int ln = 0; ln < CL; ln++) begin
            if (!merged) begin
                @(negedge cap_clk) cap_line_start = 1'b1;
                @(negedge cap_clk) cap_line_start = 1'b0;
            end
            cap_active = 1'b0;
            cap_pix    = junk;
            @(negedge cap_clk);
            for (int c = 0; c < CW; c++) begin
                cap_active     = 1'b1;
                cap_pix        = pat(f, fld, ln, c);
                cap_line_start = merged && (c == 0);
                @(negedge cap_clk);
            end
            cap_line_start = 1'b0;
            if (junk) begin
                for (int e = 0; e < 2; e++) begin
                    cap_active = 1'b1;
                    cap_pix    = 1'b1;
                    @(negedge cap_clk);
                end
            end
            cap_active = 1'b0;
            cap_pix    = junk;
            @(negedge cap_clk);
            cap_pix = 1'b0;
        end
    endtask

    task automatic vblank();
        repeat (12) @(negedge disp_clk);
        disp_vblank_start = 1'b1;
        @(negedge disp_clk) disp_vblank_start = 1'b0;
    endtask

    // f < 0 means a black picture is expected
    task automatic sweep(int f, string req);
        for (int y = 0; y < DH; y++) begin
            for (int x = 0; x < DW; x++) begin
                int  loc;
                logic e;
                loc = x >> 1;
                e   = (f < 0) ? 1'b0 : pat(f, loc & 1, y >> 1, loc >> 1);
                @(negedge disp_clk);
                disp_x   = XW'(x);
                disp_y   = YW'(y);
                disp_vis = 1'b1;
                @(negedge disp_clk);
                check(disp_pix, e, req, x, y);
                disp_vis = 1'b0;
                @(negedge disp_clk);
                check(disp_pix, 1'b0, "R9 outside window", x, y);
            end
        end
    endtask

    initial begin
        cap_rst = 1'b1; disp_rst = 1'b1;
        cap_pix = 1'b0; cap_active = 1'b0; cap_line_start = 1'b0; cap_field_start = 1'b0;
        disp_vis = 1'b0; disp_vblank_start = 1'b0; disp_x = '0; disp_y = '0;
        repeat (4) @(negedge cap_clk);
        cap_rst = 1'b0;
        @(negedge disp_clk) disp_rst = 1'b0;
        @(negedge disp_clk);
        check(disp_pix, 1'b0, "R1 reset state", 0, 0);

        // R1: a strobe without any completed frame keeps the screen dark
        vblank();
        sweep(-1, "R1 dark before first frame");

        // frame 0: plain line starts, clean window
        fs_pulse(); cap_field(0, 0, 0, 0);
        fs_pulse(); cap_field(0, 1, 0, 0);
        fs_pulse();
        sweep(-1, "R7 no swap without strobe");
        vblank();
        sweep(0, "R3 R8 woven frame");

        // frame 1: merged line starts, overrun and inactive junk
        cap_field(1, 0, 1, 1);
        fs_pulse(); cap_field(1, 1, 1, 1);
        fs_pulse();
        sweep(0, "R7 old picture held");
        vblank();
        sweep(1, "R6 R5 R2 merged start, overrun, inactive");

        // frame 2 returns to bank 0
        cap_field(2, 0, 0, 0);
        fs_pulse(); cap_field(2, 1, 0, 0);
        fs_pulse();
        vblank();
        sweep(2, "R4 bank alternation");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge disp_clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule